// File: doc/BRIEF.md
# Shared-counter capture/compare timer

This block is a timer built around one free-running up-counter. Every channel is a comparator or a capture latch on that counter; no channel has a counter of its own. A channel in compare mode toggles its output pin when the shared count steps onto the channel's register value. A channel in capture mode stores the count when its input shows the selected edge. Any channel event, and a counter rollover, leaves a sticky flag.

Because every channel watches the same timebase, the phase between outputs comes only from the spacing of their compare values. A periodic waveform is made by software adding a fixed step to a channel register after each match. The counter is never read or reset for this. The addition is modulo 2^CNT_W, so a match stays correct across a counter wrap. The counter ticks at the system clock divided by 2, 4, 8, 16, 32, 64 or 128. With a 16-bit counter and a 625 kHz tick, the longest interval the hardware produces alone is about 104 ms.

Configuration goes through a single-cycle write port. Address 0 is control: bit 0 is run, and bits 3:1 are the prescale select. Address 1 holds the channel modes, two bits per channel, with channel i at bits [2i+1:2i]. Address 2 is the flag clear. Addresses 3+i hold the channel registers.

Top module: `cc_timer`

## Requirements
- R1: While running, `count_o` advances by exactly one per prescale tick and holds between ticks. All channels observe this one counter.
- R2: A prescale select s (control bits 3:1) gives one tick every 2^(s+1) clocks for s = 0..6. s = 7 behaves as 6.
- R3: In mode 01, a channel's `cmp_out` bit toggles one clock after the counter steps onto the channel register value.
- R4: Mode 10 captures on a rising input edge and mode 11 on a falling edge; the opposite edge captures nothing. Each input passes two synchronizing flops. The captured value appears on `chan_val_o` three clock edges after the input changes. It equals the count held after the second of those edges.
- R5: A compare match or capture sets only that channel's bit in `ch_flag_o`, one clock after the event.
- R6: Flags are sticky. Writing 1 to address 2 bit i clears channel flag i, and bit NUM_CH clears the overflow flag. An event in the same cycle as its clear keeps the flag set.
- R7: Writing a channel register leaves the counter untouched. A register value advanced by modulo-2^CNT_W addition matches correctly after the counter wraps.
- R8: With run at 0, the counter is 0 one clock later and stays there. Setting run starts it from 0, and the first increment comes after one full prescale period.
- R9: `ovf_flag_o` sets one clock after the counter rolls over from all ones to 0.
- R10: A select change written while running takes effect only after the current prescale period ends. A select written while stopped applies from the start.
- R11: In mode 00, a channel neither toggles, captures nor raises its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Register write data |
| cap_in | input | NUM_CH | Asynchronous capture inputs, one per channel |
| cmp_out | output | NUM_CH | Compare toggle outputs, one per channel |
| count_o | output | CNT_W | Shared counter value |
| chan_val_o | output | NUM_CH*CNT_W | Channel registers, channel i at bits [i*CNT_W +: CNT_W] |
| ch_flag_o | output | NUM_CH | Sticky per-channel event flags |
| ovf_flag_o | output | 1 | Sticky counter rollover flag |

## Verification
The bench builds the block with an 8-bit counter and four channels. This puts a full counter wrap (512 clocks at divide-by-2) well inside the run. The rollover flag and a compare value advanced past 255 back to a small value can then be checked in cycle-exact terms. The wide control fields still fit the data word at this width. The default synchronizer depth keeps the three-edge capture latency that the expected values are computed from.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

   typedef enum logic [1:0] {
      CH_OFF      = 2'b00,
      CH_TOGGLE   = 2'b01,
      CH_CAP_RISE = 2'b10,
      CH_CAP_FALL = 2'b11
   } ch_mode_e;

   localparam int unsigned ADDR_CTRL = 0;
   localparam int unsigned ADDR_MODE = 1;
   localparam int unsigned ADDR_CLR  = 2;
   localparam int unsigned ADDR_CH0  = 3;

endpackage

// File: rtl/cc_timer_prescale.sv
module cc_timer_prescale #(
   parameter int unsigned PS_SEL_W    = 3,
   parameter int unsigned PS_MAX_LOG2 = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                load,
   input  logic [PS_SEL_W-1:0] load_sel,
   input  logic [PS_SEL_W-1:0] req_sel,
   output logic                tick
);

   localparam int unsigned DIV_W = PS_MAX_LOG2;

   logic [DIV_W-1:0]    div_q;
   logic [PS_SEL_W-1:0] act_sel_q;
   logic [DIV_W-1:0]    lim;

   if (PS_MAX_LOG2 < 1) begin : g_bad_div
      $error("cc_timer_prescale: PS_MAX_LOG2 must be at least 1");
   end
   if (PS_MAX_LOG2 > (1 << PS_SEL_W)) begin : g_bad_sel
      $error("cc_timer_prescale: PS_SEL_W too narrow for PS_MAX_LOG2");
   end

   function automatic logic [DIV_W-1:0] limit_of(input logic [PS_SEL_W-1:0] s);
      int unsigned e;
      e = (int'(s) >= int'(PS_MAX_LOG2)) ? PS_MAX_LOG2 : int'(s) + 1;
      return DIV_W'((1 << e) - 1);
   endfunction

   assign lim  = limit_of(act_sel_q);
   assign tick = run && (div_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q     <= '0;
         act_sel_q <= '0;
      end else begin
         if (load) begin
            act_sel_q <= load_sel;
         end else if (tick) begin
            act_sel_q <= req_sel;
         end
         if (!run || tick) begin
            div_q <= '0;
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

   // R2: the shortest period is two clocks
   a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R10: the active select only moves at a period boundary or while loading
   a_r10_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(act_sel_q));

endmodule

// File: rtl/cc_timer_base.sv
module cc_timer_base #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             adv,
   output logic             wrap
);

   logic [CNT_W-1:0] cnt_q;
   logic             adv_q;
   logic             wrap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         adv_q  <= 1'b0;
         wrap_q <= 1'b0;
      end else begin
         if (!run) begin
            cnt_q <= '0;
         end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
         end
         adv_q  <= run && tick;
         wrap_q <= run && tick && (cnt_q == {CNT_W{1'b1}});
      end
   end

   assign cnt  = cnt_q;
   assign adv  = adv_q;
   assign wrap = wrap_q;

   // R1: one step per tick
   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R1: no movement between ticks
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt_q));

   // R8: stopped counter reads zero
   a_r8_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));

   // R9: the rollover pulse coincides with a zero count
   a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |-> (cnt_q == '0));

endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
   import cc_timer_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ch_mode_e         mode,
   input  logic [CNT_W-1:0] cnt,
   input  logic             adv,
   input  logic             wr_val,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             clr,
   input  logic             cap_in,
   output logic             pin,
   output logic             flag,
   output logic [CNT_W-1:0] val
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   synced;
   logic                   rise;
   logic                   fall;
   logic                   match;
   logic                   cap;
   logic                   evt;
   logic [CNT_W-1:0]       val_q;
   logic                   pin_q;
   logic                   flag_q;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cc_timer_chan: SYNC_STAGES must be at least 2");
   end

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= cap_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   assign synced = sync_q[SYNC_STAGES-1];
   assign rise   = synced && !prev_q;
   assign fall   = !synced && prev_q;
   assign match  = (mode == CH_TOGGLE) && adv && (cnt == val_q);
   assign cap    = ((mode == CH_CAP_RISE) && rise) || ((mode == CH_CAP_FALL) && fall);
   assign evt    = match || cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         val_q  <= '0;
         pin_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= synced;
         if (cap) begin
            val_q <= cnt;
         end else if (wr_val) begin
            val_q <= wr_data;
         end
         if (match) begin
            pin_q <= !pin_q;
         end
         flag_q <= (flag_q && !clr) || evt;
      end
   end

   assign pin  = pin_q;
   assign flag = flag_q;
   assign val  = val_q;

   // R3: a step onto the register value flips the pin
   a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == CH_TOGGLE) && adv && (cnt == val)) |=> (pin != $past(pin)));

   // R4: a captured value is the count of the detecting cycle
   a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (val == $past(cnt)));

   // R6: set wins over clear
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag);

   // R6: flags stay until cleared
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

   // R11: an idle channel leaves its pin alone
   a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CH_OFF) |=> $stable(pin));

endmodule

// File: rtl/cc_timer.sv
module cc_timer
   import cc_timer_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned PS_SEL_W    = 3,
   parameter int unsigned PS_MAX_LOG2 = 7,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = $clog2(NUM_CH + ADDR_CH0)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [CNT_W-1:0]        wr_data,
   input  logic [NUM_CH-1:0]       cap_in,
   output logic [NUM_CH-1:0]       cmp_out,
   output logic [CNT_W-1:0]        count_o,
   output logic [NUM_CH*CNT_W-1:0] chan_val_o,
   output logic [NUM_CH-1:0]       ch_flag_o,
   output logic                    ovf_flag_o
);

   localparam int unsigned MODE_W = 2 * NUM_CH;
   localparam int unsigned CLR_W  = NUM_CH + 1;

   if (CNT_W < MODE_W || CNT_W < CLR_W || CNT_W < PS_SEL_W + 1) begin : g_bad_width
      $error("cc_timer: CNT_W too narrow for the control fields");
   end
   if ((NUM_CH + ADDR_CH0) > (1 << ADDR_W)) begin : g_bad_addr
      $error("cc_timer: ADDR_W too narrow for the register space");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("cc_timer: NUM_CH must be at least 1");
   end

   logic                          run_q;
   logic [PS_SEL_W-1:0]           sel_q;
   logic [NUM_CH-1:0][1:0]        mode_q;
   logic                          ovf_q;
   logic                          ctrl_wr;
   logic                          mode_wr;
   logic                          clr_wr;
   logic [CLR_W-1:0]              clr_vec;
   logic                          tick;
   logic [CNT_W-1:0]              cnt;
   logic                          adv;
   logic                          wrap;
   logic                          unused_wr;

   assign ctrl_wr   = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
   assign mode_wr   = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));
   assign clr_wr    = wr_en && (wr_addr == ADDR_W'(ADDR_CLR));
   assign clr_vec   = clr_wr ? wr_data[CLR_W-1:0] : '0;
   assign unused_wr = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         sel_q  <= '0;
         mode_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            run_q <= wr_data[0];
            sel_q <= wr_data[PS_SEL_W:1];
         end
         if (mode_wr) begin
            mode_q <= wr_data[MODE_W-1:0];
         end
         ovf_q <= (ovf_q && !clr_vec[NUM_CH]) || wrap;
      end
   end

   cc_timer_prescale #(
      .PS_SEL_W   (PS_SEL_W),
      .PS_MAX_LOG2(PS_MAX_LOG2)
   ) u_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .load    (ctrl_wr && !run_q),
      .load_sel(wr_data[PS_SEL_W:1]),
      .req_sel (sel_q),
      .tick    (tick)
   );

   cc_timer_base #(
      .CNT_W(CNT_W)
   ) u_base (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run_q),
      .tick (tick),
      .cnt  (cnt),
      .adv  (adv),
      .wrap (wrap)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [CNT_W-1:0] val_i;
      logic             ch_wr;

      assign ch_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CH0 + i));

      cc_timer_chan #(
         .CNT_W      (CNT_W),
         .SYNC_STAGES(SYNC_STAGES)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .mode   (ch_mode_e'(mode_q[i])),
         .cnt    (cnt),
         .adv    (adv),
         .wr_val (ch_wr),
         .wr_data(wr_data),
         .clr    (clr_vec[i]),
         .cap_in (cap_in[i]),
         .pin    (cmp_out[i]),
         .flag   (ch_flag_o[i]),
         .val    (val_i)
      );

      assign chan_val_o[i*CNT_W +: CNT_W] = val_i;
   end

   assign count_o    = cnt;
   assign ovf_flag_o = ovf_q;

   // R9: a rollover raises the overflow flag on the next clock
   a_r9_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ovf_flag_o);

   // R7: writing a channel register does not disturb a stopped counter
   a_r7_write_no_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !ctrl_wr) |=> (count_o == '0));

endmodule

// File: tb/test_cc_timer.sv
module test_cc_timer;

   localparam int CW  = 8;
   localparam int NCH = 4;
   localparam int AW  = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     wr_addr = '0;
   logic [CW-1:0]     wr_data = '0;
   logic [NCH-1:0]    cap_in = '0;
   logic [NCH-1:0]    cmp_out;
   logic [CW-1:0]     count_o;
   logic [NCH*CW-1:0] chan_val_o;
   logic [NCH-1:0]    ch_flag_o;
   logic              ovf_flag_o;

   cc_timer #(
      .CNT_W (CW),
      .NUM_CH(NCH),
      .ADDR_W(AW)
   ) i_cc_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cap_in    (cap_in),
      .cmp_out   (cmp_out),
      .count_o   (count_o),
      .chan_val_o(chan_val_o),
      .ch_flag_o (ch_flag_o),
      .ovf_flag_o(ovf_flag_o)
   );

   always #4 clk = ~clk;

   int unsigned edge_n = 0;
   always @(posedge clk) edge_n <= edge_n + 1;

   // observation selectors
   localparam int OB_CNT  = 0;
   localparam int OB_PINS = 1;
   localparam int OB_FLG  = 2;
   localparam int OB_OVF  = 3;
   localparam int OB_VAL0 = 4;

   typedef struct {
      string req;
      int    sel;
      int    val;
   } item_t;

   item_t       sb_q[$];
   event        sample_ev;
   int          checks = 0;
   int          fails  = 0;
   int unsigned t0 = 0;
   bit          done = 1'b0;

   function automatic int observe(int sel);
      case (sel)
         OB_CNT:  return int'(count_o);
         OB_PINS: return int'(cmp_out);
         OB_FLG:  return int'(ch_flag_o);
         OB_OVF:  return int'(ovf_flag_o);
         default: return int'(chan_val_o[(sel-OB_VAL0)*CW +: CW]);
      endcase
   endfunction

   // monitor: pops expected items and compares with the outputs
   initial begin
      forever begin
         @(sample_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            int    got;
            it  = sb_q.pop_front();
            got = observe(it.sel);
            checks++;
            if (got != it.val) begin
               fails++;
               $display("FAIL %s (view %0d) at edge %0d: got %0d expected %0d",
                        it.req, it.sel, edge_n, got, it.val);
            end
         end
      end
   end

   task automatic expect_v(string req, int sel, int val);
      sb_q.push_back('{req, sel, val});
      -> sample_ev;
   endtask

   task automatic reg_wr(int a, int d);
      wr_en   = 1'b1;
      wr_addr = AW'(a);
      wr_data = CW'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic at_t(int unsigned n);
      while (edge_n < t0 + n) @(negedge clk);
   endtask

   task automatic finish_run();
      #1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired at edge %0d", edge_n);
         finish_run();
      end
   end

   initial begin
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      expect_v("R8 reset count", OB_CNT, 0);
      expect_v("R3 reset pins", OB_PINS, 0);
      expect_v("R5 reset flags", OB_FLG, 0);
      expect_v("R9 reset overflow", OB_OVF, 0);

      // four outputs spaced 10 ticks apart, divide by 2
      reg_wr(3, 10);
      reg_wr(4, 20);
      reg_wr(5, 30);
      reg_wr(6, 40);
      reg_wr(1, 'h55);
      reg_wr(0, 1);
      t0 = edge_n;

      at_t(1);  expect_v("R8 starts at zero", OB_CNT, 0);
      at_t(2);  expect_v("R8 first step after full period", OB_CNT, 1);
      at_t(10); expect_v("R1 count at divide 2", OB_CNT, 5);
      at_t(20); expect_v("R3 no toggle before match", OB_PINS, 0);
      at_t(21); expect_v("R3 ch0 toggles", OB_PINS, 1);
                expect_v("R5 only ch0 flag", OB_FLG, 1);
      at_t(41); expect_v("R3 ch1 phase", OB_PINS, 3);
                expect_v("R5 ch1 flag", OB_FLG, 3);
      at_t(61); expect_v("R3 ch2 phase", OB_PINS, 7);
      at_t(81); expect_v("R3 ch3 phase", OB_PINS, 15);
                expect_v("R5 all flags", OB_FLG, 15);

      // periodic reload by adding a step; ch3 step wraps past the top
      at_t(82);
      reg_wr(3, 10 + 40);
      reg_wr(6, (40 + 240) % 256);
      at_t(85); expect_v("R7 compare write keeps count", OB_CNT, 42);

      // clear ch0 flag in the same cycle as its second match
      at_t(100);
      reg_wr(2, 1);
      expect_v("R7 periodic second toggle", OB_PINS, 14);
      expect_v("R6 set wins over clear", OB_FLG, 15);
      reg_wr(2, 2);
      expect_v("R6 write one clears ch1", OB_FLG, 13);

      // wrap
      at_t(511); expect_v("R1 top of count", OB_CNT, 255);
      at_t(512); expect_v("R1 rolls to zero", OB_CNT, 0);
                 expect_v("R9 not yet set", OB_OVF, 0);
      at_t(513); expect_v("R9 overflow flag", OB_OVF, 1);
      at_t(553); expect_v("R3 ch1 after wrap", OB_PINS, 12);
      at_t(560); expect_v("R7 ch3 not yet", OB_PINS, 12);
      at_t(561); expect_v("R7 wrapped compare match", OB_PINS, 4);
                 expect_v("R5 ch1 flag again", OB_FLG, 15);
      reg_wr(2, 16);
      expect_v("R9 overflow clear", OB_OVF, 0);

      // stop
      reg_wr(0, 0);
      @(negedge clk);
      expect_v("R8 stop clears count", OB_CNT, 0);
      repeat (5) @(negedge clk);
      expect_v("R8 stays zero", OB_CNT, 0);

      // divide by 8, then a select change while running
      reg_wr(0, 5);
      t0 = edge_n;
      at_t(7);  expect_v("R2 no step before 8", OB_CNT, 0);
      at_t(8);  expect_v("R2 step at 8", OB_CNT, 1);
      at_t(24); expect_v("R2 divide 8", OB_CNT, 3);
      at_t(25);
      reg_wr(0, 1);
      at_t(31); expect_v("R10 old period kept", OB_CNT, 3);
      at_t(32); expect_v("R10 period ends", OB_CNT, 4);
      at_t(34); expect_v("R10 new select", OB_CNT, 5);
      at_t(36); expect_v("R10 new select steady", OB_CNT, 6);

      // capture: ch0 rising, ch1 falling, ch2 and ch3 off
      reg_wr(1, 'h0E);
      reg_wr(2, 'h1F);
      expect_v("R6 clear all", OB_FLG, 0);

      cap_in[0] = 1'b1;
      repeat (2) @(negedge clk);
      c = int'(count_o);
      @(negedge clk);
      expect_v("R4 rising capture value", OB_VAL0 + 0, c);
      expect_v("R5 capture flag ch0", OB_FLG, 1);
      cap_in[0] = 1'b0;
      repeat (6) @(negedge clk);
      expect_v("R4 falling ignored on ch0", OB_VAL0 + 0, c);

      cap_in[1] = 1'b1;
      repeat (6) @(negedge clk);
      expect_v("R4 rising ignored on ch1", OB_VAL0 + 1, 20);
      expect_v("R4 no flag on ignored edge", OB_FLG, 1);
      cap_in[1] = 1'b0;
      repeat (2) @(negedge clk);
      c = int'(count_o);
      @(negedge clk);
      expect_v("R4 falling capture value", OB_VAL0 + 1, c);
      expect_v("R5 capture flag ch1", OB_FLG, 3);

      // idle channels through a full sweep of the counter
      cap_in[2] = 1'b1;
      repeat (20) @(negedge clk);
      cap_in[2] = 1'b0;
      repeat (600) @(negedge clk);
      expect_v("R11 idle pins hold", OB_PINS, 4);
      expect_v("R11 idle flags stay clear", OB_FLG, 3);
      expect_v("R11 idle no capture", OB_VAL0 + 2, 30);
      expect_v("R11 idle ch3 register", OB_VAL0 + 3, 24);

      done = 1'b1;
      finish_run();
   end

endmodule